// File: doc/BRIEF.md
# Load/Store Address and Byte-Lane Alignment Unit

This unit sits between a register file and a 64-bit memory data path. For each load or store it forms the effective address in one of two ways: base register plus a sign-extended 13-bit displacement, or base register plus an index register. It then checks that the address is a multiple of the access size. An access may be one, two, four or eight bytes. The unit also works out which of the eight byte lanes of the memory word the access touches.

For stores, the unit places the operand bytes of the register into the addressed lanes. For loads, it collects the addressed lanes into a 64-bit register value and sign-extends or zero-extends that value. The byte order is chosen per access by a run-time control, so little-endian and big-endian accesses can be mixed cycle by cycle. A misaligned access raises a fault flag and drives no lanes. The datapath is combinational. A single register stage holds all results, so each result appears exactly one clock after its request.

Top module: `lsAlignUnit`

## Requirements
- R1: With `modeSel`=0 the effective address is `baseVal` plus `dispVal` taken as a 13-bit two's complement number sign-extended to 64 bits (for example `dispVal`=13'h1FF8 means -8).
- R2: With `modeSel`=1 the effective address is `baseVal` plus `indexVal`, wrapping modulo 2^64.
- R3: `accSize` encodes the access width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. An access whose address is not a multiple of its width sets `misalign`. In that case `byteEn`, `memWdata` and `loadData` are all zero.
- R4: For an aligned valid access, with off = effAddr[2:0] and n the width in bytes, `byteEn` has exactly lanes off to off+n-1 set. Lane k is bits [8k+7:8k] of the memory bus and holds the byte at address (effAddr with bits [2:0] cleared) + k.
- R5: For a little-endian store (`bigEndian`=0), operand byte j of `storeData` (byte 0 = bits [7:0]) appears on lane off+j of `memWdata`.
- R6: For a big-endian store (`bigEndian`=1), operand byte j appears on lane off+n-1-j, so the most significant byte sits at the lowest address. Lanes that are not enabled are zero, and `memWdata` is zero for loads.
- R7: For a little-endian load, byte j of the result is taken from lane off+j of `memRdata`.
- R8: For a big-endian load, byte j of the result is taken from lane off+n-1-j of `memRdata`.
- R9: With `isSigned`=1 a load copies bit 8n-1 of the result into all higher bits; with `isSigned`=0 the higher bits are zero. `loadData` is zero for stores.
- R10: All outputs are registered. `outValid` equals `inValid` from one clock earlier, and all outputs come from the inputs of that earlier cycle. Reset clears every output. When `outValid` is 0, `byteEn` and `misalign` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request present this cycle |
| isStore | input | 1 | 1 = store, 0 = load |
| modeSel | input | 1 | 0 = base + displacement, 1 = base + index |
| accSize | input | 2 | Access width code (R3) |
| isSigned | input | 1 | Sign-extend load result |
| bigEndian | input | 1 | Byte order of this access |
| baseVal | input | 64 | Base register value |
| indexVal | input | 64 | Index register value |
| dispVal | input | 13 | Signed displacement field |
| storeData | input | 64 | Register value to store |
| memRdata | input | 64 | Memory read data word |
| outValid | output | 1 | Registered result present |
| effAddr | output | 64 | Effective address |
| byteEn | output | 8 | Byte-lane enables |
| memWdata | output | 64 | Store data placed on lanes |
| loadData | output | 64 | Extended load result |
| misalign | output | 1 | Misaligned access fault |

## Verification
The hardest case to reach is a big-endian sub-word access at a high lane offset. That case needs a wide access width, the reversed byte order and an address whose low bits land near the top of the word, all at once, and the steering index then runs downward from off+n-1. Directed vectors place half-word and word accesses at offsets 4 and 6 in both byte orders, with a read word whose bytes are all distinct, so that any lane swap shows up in the result. Misalignment is reached through the displacement mode by mixing a negative displacement with an aligned base. A long run of generated vectors then forces the low address bits to aligned values most of the time and leaves them free the rest of the time.

// File: rtl/lsauPkg.sv
package lsauPkg;
  localparam int LANES = 8;
  localparam int OFF_W = $clog2(LANES);
  localparam int DATA_W = 8 * LANES;

  typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD, SZ_DWORD} accSize_e;

  typedef struct packed {
    logic [LANES-1:0] laneEn;
    logic [OFF_W-1:0] laneOff;
    logic [OFF_W:0]   nBytes;
    logic             bigEnd;
    logic             signExt;
    logic             doLoad;
    logic             doStore;
    logic             fault;
  } ctrlStrobe_t;
endpackage

// File: rtl/lsauCtrl.sv
module lsauCtrl
  import lsauPkg::*;
(
  input  logic             inValid,
  input  logic             isStore,
  input  logic [1:0]       accSize,
  input  logic             isSigned,
  input  logic             bigEndian,
  input  logic [OFF_W-1:0] addrLow,
  output ctrlStrobe_t      strobe
);
  logic [OFF_W:0]   sizeBytes;
  logic [OFF_W-1:0] alignMask;
  logic [OFF_W:0]   laneEnd;
  logic             faultHit;
  logic             okAccess;
  logic [LANES-1:0] laneEn;

  // Width in bytes from the size code; the low address bits must be clear under the mask.
  assign sizeBytes = (OFF_W+1)'(1) << accSize;
  assign alignMask = OFF_W'(sizeBytes - (OFF_W+1)'(1));
  assign faultHit  = inValid && ((addrLow & alignMask) != '0);
  assign okAccess  = inValid && !faultHit;
  assign laneEnd   = {1'b0, addrLow} + sizeBytes;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign laneEn[k] = okAccess &&
                       ((OFF_W+1)'(k) >= {1'b0, addrLow}) &&
                       ((OFF_W+1)'(k) < laneEnd);
  end

  always_comb begin
    strobe.laneEn  = laneEn;
    strobe.laneOff = addrLow;
    strobe.nBytes  = sizeBytes;
    strobe.bigEnd  = bigEndian;
    strobe.signExt = isSigned;
    strobe.doLoad  = okAccess && !isStore;
    strobe.doStore = okAccess && isStore;
    strobe.fault   = faultHit;
  end
endmodule

// File: rtl/lsauData.sv
module lsauData
  import lsauPkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DISP_W = 13
) (
  input  logic              modeSel,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] indexVal,
  input  logic [DISP_W-1:0] dispVal,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] memRdata,
  input  ctrlStrobe_t       strobe,
  output logic [ADDR_W-1:0] effAddr,
  output logic [OFF_W-1:0]  addrLow,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] ldData
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] dispExt;
  logic [ADDR_W-1:0] addend;
  logic [DATA_W-1:0] gathered;
  logic              signBit;

  assign dispExt = {{EXT_W{dispVal[DISP_W-1]}}, dispVal};
  assign addend  = modeSel ? indexVal : dispExt;
  assign effAddr = baseVal + addend;
  assign addrLow = effAddr[OFF_W-1:0];

  // Store steering: for each lane, find which operand byte feeds it.
  always_comb begin
    int src;
    logic [OFF_W-1:0] srcLane;
    wrData = '0;
    for (int k = 0; k < LANES; k++) begin
      src = strobe.bigEnd ? (int'(strobe.laneOff) + int'(strobe.nBytes) - 1 - k)
                          : (k - int'(strobe.laneOff));
      srcLane = src[OFF_W-1:0];
      if (strobe.doStore && strobe.laneEn[k])
        wrData[k*8 +: 8] = storeData[{srcLane, 3'b000} +: 8];
    end
  end

  // Load gather: for each result byte, find the lane that feeds it.
  always_comb begin
    int lane;
    logic [OFF_W-1:0] laneSel;
    gathered = '0;
    for (int j = 0; j < LANES; j++) begin
      lane = strobe.bigEnd ? (int'(strobe.laneOff) + int'(strobe.nBytes) - 1 - j)
                           : (int'(strobe.laneOff) + j);
      laneSel = lane[OFF_W-1:0];
      if (j < int'(strobe.nBytes))
        gathered[j*8 +: 8] = memRdata[{laneSel, 3'b000} +: 8];
    end
  end

  assign signBit = strobe.signExt && gathered[{strobe.nBytes, 3'b000} - 1'b1];

  always_comb begin
    ldData = '0;
    if (strobe.doLoad) begin
      for (int j = 0; j < LANES; j++)
        ldData[j*8 +: 8] = (j < int'(strobe.nBytes)) ? gathered[j*8 +: 8] : {8{signBit}};
    end
  end
endmodule

// File: rtl/lsAlignUnit.sv
module lsAlignUnit
  import lsauPkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DISP_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              isStore,
  input  logic              modeSel,
  input  logic [1:0]        accSize,
  input  logic              isSigned,
  input  logic              bigEndian,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] indexVal,
  input  logic [DISP_W-1:0] dispVal,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] memRdata,
  output logic              outValid,
  output logic [ADDR_W-1:0] effAddr,
  output logic [LANES-1:0]  byteEn,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] loadData,
  output logic              misalign
);
  ctrlStrobe_t       strobe;
  logic [ADDR_W-1:0] addrComb;
  logic [OFF_W-1:0]  addrLow;
  logic [DATA_W-1:0] wrComb;
  logic [DATA_W-1:0] ldComb;

  lsauCtrl i_ctrl (
    .inValid  (inValid),
    .isStore  (isStore),
    .accSize  (accSize),
    .isSigned (isSigned),
    .bigEndian(bigEndian),
    .addrLow  (addrLow),
    .strobe   (strobe)
  );

  lsauData #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) i_data (
    .modeSel  (modeSel),
    .baseVal  (baseVal),
    .indexVal (indexVal),
    .dispVal  (dispVal),
    .storeData(storeData),
    .memRdata (memRdata),
    .strobe   (strobe),
    .effAddr  (addrComb),
    .addrLow  (addrLow),
    .wrData   (wrComb),
    .ldData   (ldComb)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      effAddr  <= '0;
      byteEn   <= '0;
      memWdata <= '0;
      loadData <= '0;
      misalign <= 1'b0;
    end else begin
      outValid <= inValid;
      effAddr  <= addrComb;
      byteEn   <= strobe.laneEn;
      memWdata <= wrComb;
      loadData <= ldComb;
      misalign <= strobe.fault;
    end
  end
endmodule

// File: rtl/lsauChecker.sv
module lsauChecker #(
  parameter int ADDR_W = 64,
  parameter int DISP_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              isStore,
  input logic              modeSel,
  input logic [1:0]        accSize,
  input logic [ADDR_W-1:0] baseVal,
  input logic [ADDR_W-1:0] indexVal,
  input logic [DISP_W-1:0] dispVal,
  input logic              outValid,
  input logic [ADDR_W-1:0] effAddr,
  input logic [7:0]        byteEn,
  input logic [63:0]       memWdata,
  input logic [63:0]       loadData,
  input logic              misalign
);
  logic [ADDR_W-1:0] dispWide;
  assign dispWide = {{(ADDR_W-DISP_W){dispVal[DISP_W-1]}}, dispVal};

  assert_addr_disp_R1: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !modeSel |=> effAddr == $past(baseVal) + $past(dispWide));

  assert_addr_index_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid && modeSel |=> effAddr == $past(baseVal) + $past(indexVal));

  assert_fault_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    misalign |-> (byteEn == '0) && (memWdata == '0) && (loadData == '0));

  assert_fault_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> misalign == ((effAddr[2:0] & (3'((4'd1 << $past(accSize)) - 4'd1))) != 3'd0));

  assert_lane_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> misalign || ($countones(byteEn) == (32'd1 << $past(accSize))));

  assert_load_no_wdata_R6: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !isStore |=> memWdata == '0);

  assert_store_no_rdata_R9: assert property (@(posedge clk) disable iff (!rstN)
    inValid && isStore |=> loadData == '0);

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> outValid == $past(inValid));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (byteEn == '0) && !misalign);
endmodule

bind lsAlignUnit lsauChecker #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) i_lsauChecker (
  .clk(clk), .rstN(rstN), .inValid(inValid), .isStore(isStore), .modeSel(modeSel),
  .accSize(accSize), .baseVal(baseVal), .indexVal(indexVal), .dispVal(dispVal),
  .outValid(outValid), .effAddr(effAddr), .byteEn(byteEn), .memWdata(memWdata),
  .loadData(loadData), .misalign(misalign)
);

// File: tb/test_lsAlignUnit.sv
`timescale 1ns/1ps
module test_lsAlignUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, isStore = 1'b0, modeSel = 1'b0;
  logic [1:0]  accSize = '0;
  logic        isSigned = 1'b0, bigEndian = 1'b0;
  logic [63:0] baseVal = '0, indexVal = '0, storeData = '0, memRdata = '0;
  logic [12:0] dispVal = '0;
  logic        outValid, misalign;
  logic [63:0] effAddr, memWdata, loadData;
  logic [7:0]  byteEn;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [63:0] addr;
    logic [7:0]  be;
    logic [63:0] wd;
    logic [63:0] ld;
    logic        mis;
    string       req;
  } expItem_t;

  expItem_t expQ[$];

  always #4 clk = ~clk;

  lsAlignUnit i_lsAlignUnit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .isStore(isStore), .modeSel(modeSel),
    .accSize(accSize), .isSigned(isSigned), .bigEndian(bigEndian), .baseVal(baseVal),
    .indexVal(indexVal), .dispVal(dispVal), .storeData(storeData), .memRdata(memRdata),
    .outValid(outValid), .effAddr(effAddr), .byteEn(byteEn), .memWdata(memWdata),
    .loadData(loadData), .misalign(misalign)
  );

  task automatic check64(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected result built from the requirements, byte by byte.
  function automatic expItem_t model(input logic md, input logic [1:0] sz, input logic sg,
      input logic bend, input logic st, input logic [63:0] b, input logic [63:0] ix,
      input logic [12:0] d, input logic [63:0] sd, input logic [63:0] rd, input string req);
    expItem_t e;
    int n, off, lane;
    logic [63:0] tmp;
    e.req = req;
    e.addr = md ? (b + ix) : (b + {{51{d[12]}}, d});   // R1, R2
    n = 1 << sz;
    off = int'(e.addr[2:0]);
    e.mis = (off % n) != 0;                              // R3
    e.be = '0; e.wd = '0; tmp = '0;
    if (!e.mis) begin
      for (int i = 0; i < n; i++) begin
        lane = bend ? (off + n - 1 - i) : (off + i);     // R5..R8
        e.be[lane] = 1'b1;                                // R4
        if (st) e.wd[lane*8 +: 8] = sd[i*8 +: 8];
        else    tmp[i*8 +: 8] = rd[lane*8 +: 8];
      end
      if (!st && sg && tmp[8*n-1])                        // R9
        for (int i = n; i < 8; i++) tmp[i*8 +: 8] = 8'hFF;
    end
    e.ld = tmp;
    return e;
  endfunction

  task automatic drive(input string req, input logic st, input logic md, input logic [1:0] sz,
      input logic sg, input logic bend, input logic [63:0] b, input logic [63:0] ix,
      input logic [12:0] d, input logic [63:0] sd, input logic [63:0] rd);
    @(negedge clk);
    inValid = 1'b1; isStore = st; modeSel = md; accSize = sz; isSigned = sg;
    bigEndian = bend; baseVal = b; indexVal = ix; dispVal = d; storeData = sd; memRdata = rd;
    expQ.push_back(model(md, sz, sg, bend, st, b, ix, d, sd, rd, req));
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  // Monitor: results appear one clock after the request (R10).
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          testsRun++; testsFailed++;
          $display("FAIL R10 outValid without request actual=1 expected=0");
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check64(e.req, "effAddr", effAddr, e.addr);
          check64(e.req, "byteEn", {56'd0, byteEn}, {56'd0, e.be});
          check64(e.req, "memWdata", memWdata, e.wd);
          check64(e.req, "loadData", loadData, e.ld);
          check64(e.req, "misalign", {63'd0, misalign}, {63'd0, e.mis});
        end
      end else begin
        check64("R10", "idle byteEn", {56'd0, byteEn}, 64'd0);
        check64("R10", "idle misalign", {63'd0, misalign}, 64'd0);
      end
    end
  end

  localparam logic [63:0] RD = 64'h8877_6655_4433_2211;

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset clears every output
    check64("R10", "reset outValid", {63'd0, outValid}, 64'd0);
    check64("R10", "reset effAddr", effAddr, 64'd0);
    check64("R10", "reset byteEn", {56'd0, byteEn}, 64'd0);
    check64("R10", "reset memWdata", memWdata, 64'd0);
    check64("R10", "reset loadData", loadData, 64'd0);
    rstN = 1'b1;
    idle(2);

    // R1: negative and largest positive displacement
    drive("R1", 0, 0, 2'd3, 0, 0, 64'h1000, 64'h0, 13'h1FF8, 64'h0, RD);
    drive("R1", 0, 0, 2'd0, 0, 0, 64'h2000, 64'h0, 13'h0FFF, 64'h0, RD);
    // R2: index mode with wrap
    drive("R2", 0, 1, 2'd0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h10, 13'h0, 64'h0, RD);
    // R3: misaligned half, word, double, and a misaligned store
    drive("R3", 0, 0, 2'd1, 1, 0, 64'h101, 64'h0, 13'h0, 64'h0, RD);
    drive("R3", 0, 1, 2'd2, 0, 1, 64'h100, 64'h2, 13'h0, 64'h0, RD);
    drive("R3", 1, 0, 2'd3, 0, 0, 64'h108, 64'h0, 13'h1FFC, 64'hDEAD_BEEF_0BAD_F00D, RD);
    // R4 / R5: little-endian word store at offset 4
    drive("R5", 1, 0, 2'd2, 0, 0, 64'h204, 64'h0, 13'h0, 64'h1122_3344, RD);
    // R6: big-endian word store at offset 4, byte store at offset 3
    drive("R6", 1, 0, 2'd2, 0, 1, 64'h204, 64'h0, 13'h0, 64'h1122_3344, RD);
    drive("R6", 1, 1, 2'd0, 0, 1, 64'h200, 64'h3, 13'h0, 64'hAB, RD);
    // R7: little-endian half load at offset 6, unsigned and signed
    drive("R7", 0, 0, 2'd1, 0, 0, 64'h306, 64'h0, 13'h0, 64'h0, RD);
    drive("R9", 0, 0, 2'd1, 1, 0, 64'h306, 64'h0, 13'h0, 64'h0, RD);
    // R8: big-endian half at offset 6, word at 0, double
    drive("R8", 0, 0, 2'd1, 1, 1, 64'h306, 64'h0, 13'h0, 64'h0, RD);
    drive("R8", 0, 0, 2'd2, 0, 1, 64'h300, 64'h0, 13'h0, 64'h0, RD);
    drive("R8", 0, 0, 2'd3, 0, 1, 64'h300, 64'h0, 13'h0, 64'h0, RD);
    drive("R4", 1, 0, 2'd3, 0, 0, 64'h300, 64'h0, 13'h0, 64'h0102_0304_0506_0708, RD);
    // R9: signed byte load of 0x80, and unsigned
    drive("R9", 0, 0, 2'd0, 1, 0, 64'h400, 64'h0, 13'h0, 64'h0, 64'h80);
    drive("R9", 0, 0, 2'd0, 0, 1, 64'h400, 64'h0, 13'h0, 64'h0, 64'h80);
    idle(3);  // R10: gap with no request

    // Generated vectors across every mode, width and order
    for (int v = 0; v < 400; v++) begin
      logic [63:0] b;
      b = {$urandom, $urandom};
      if (($urandom % 4) != 0) b[2:0] = 3'd0;
      drive("R4", 1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
            b, {$urandom, $urandom} & 64'hFFFF_FFFF_FFFF_FFF8 | 64'(($urandom % 8) == 0),
            13'($urandom) & 13'h1FF8, {$urandom, $urandom}, {$urandom, $urandom});
      if ((v % 37) == 0) idle(1);
    end
    idle(3);
    if (expQ.size() != 0) begin
      testsRun++; testsFailed++;
      $display("FAIL R10 pending results actual=%0d expected=0", expQ.size());
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testsRun++; testsFailed++;
      $display("FAIL R10 watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule